// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Cache

This block is a unified cache for instructions and data. It sits between a 32-bit processor request port and a slower 32-bit memory port. The default geometry holds 8 KB as 128 sets of four ways, with 16-byte lines. The cache holds tag storage, line storage, one valid bit per way and per-set recency state. A read that hits returns its word on the cycle after it is accepted. A read that misses fetches the whole line with four single-word memory reads, installs the line and then returns the requested word. Every write goes to memory. A write that hits also updates the cached word. A write that misses leaves the cache unchanged.

The block handles one request at a time. The controller has three states. In ST_IDLE the cache accepts requests and looks up the tags. ST_IDLE moves to ST_FILL on an accepted read miss and to ST_WRITE on any accepted write. An accepted read hit leaves the controller in ST_IDLE. In ST_FILL the controller issues line beats and returns to ST_IDLE when the last beat is acknowledged. In ST_WRITE it holds one memory write and returns to ST_IDLE when that write is acknowledged. A one-cycle invalidate-all input clears the whole cache.

Top module: `wt_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and every line is invalid, so the first read misses.
- R2: When a read hits, rsp_valid rises with the cached word in the cycle after acceptance, and no memory request is issued.
- R3: When a read misses, the cache issues exactly four memory reads with mem_we=0. The addresses are the line base plus 0, 4, 8 and 12, in that order. The cache then responds with the requested word, and the line becomes valid.
- R4: Each write produces exactly one memory write with mem_we=1, using the request address and data unchanged. While mem_ack is low, mem_addr, mem_we and mem_wdata hold steady. rsp_valid follows the acknowledge.
- R5: A write that hits also updates the cached word, so a later read hit returns the new value.
- R6: A write that misses allocates no line, so a later read of that address misses.
- R7: While a set still has an invalid way, a fill takes an invalid way and evicts nothing. Four distinct lines in one set therefore all stay resident.
- R8: When all four ways of a set are valid, a fill replaces the least recently used way.
- R9: Recency is refreshed by each read hit, each write hit and each completed fill.
- R10: Invalidate-all drops req_ready for that cycle. It clears every valid bit at once and resets the recency state.
- R11: Every accepted request raises exactly one of lookup_hit or lookup_miss, in the cycle after acceptance.
- R12: The address splits into a 21-bit tag in bits 31:11, a 7-bit set index in bits 10:4 and a word select in bits 3:2. On reads, bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_all | input | 1 | Invalidate every line this cycle |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid on reads |
| lookup_hit | output | 1 | Pulse: accepted request hit |
| lookup_miss | output | 1 | Pulse: accepted request missed |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory beat completes on this edge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The hardest situation to reach is replacement in a full set whose recency order has been reshuffled by hits and by writes. Random addresses almost never put five or more tags into one set. The stimulus therefore builds addresses from a chosen tag and set. It fills one set with four tags, touches them in a chosen order with read hits and write hits, and then brings in a fifth tag. Whether a later access to each older tag hits or misses shows which way was evicted. That result is compared with a recency-ordered queue kept for each set, and every read word is compared with a reference memory.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int TAG_W = 21,
    parameter int IDX_W = 7,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [WAYS-1:0]  valid_vec,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    // Valid bits: invalidate wins over a completing fill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (inval) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
    end

    assign valid_vec = valid_q[lk_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    parameter int IDX_W      = 7,
    parameter int WAY_W      = 2,
    parameter int WSEL_W     = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] line_mem [SETS][WAYS][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) line_mem[wr_idx][wr_way][wr_word] <= wr_data;
    end

    assign rd_data = line_mem[rd_idx][rd_way][rd_word];
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] q_idx,
    input  logic [WAYS-1:0]  q_valid,
    output logic [WAY_W-1:0] victim_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    // Age per way: 0 = most recent, WAYS-1 = least recent; a permutation per set.
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx][touch_way];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end else if (inval) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_idx][w] <= '0;
                else if (age_q[touch_idx][w] < touched_age)
                    age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
            end
        end
    end

    // Lowest-numbered invalid way first, otherwise the oldest way.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !q_valid[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[q_idx][w] == OLDEST) victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/wt_cache.sv
module wt_cache import cache_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              lookup_hit,
    output logic              lookup_miss,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + BYTE_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    cache_state_e state_q, state_d;

    logic [ADDR_W-1:0] cur_addr_q;
    logic [WORD_W-1:0] cur_wdata_q;
    logic [WAY_W-1:0]  victim_q;
    logic [WSEL_W-1:0] beat_q;
    logic [WORD_W-1:0] cap_q;
    logic              rsp_valid_q, hit_q, miss_q;
    logic [WORD_W-1:0] rsp_rdata_q;

    // Request-side address fields
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_word;
    assign lk_idx  = req_addr[OFF_W +: IDX_W];
    assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign lk_word = req_addr[BYTE_W +: WSEL_W];

    // Fields of the request in progress
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [WSEL_W-1:0] cur_word;
    assign cur_idx  = cur_addr_q[OFF_W +: IDX_W];
    assign cur_tag  = cur_addr_q[ADDR_W-1 -: TAG_W];
    assign cur_word = cur_addr_q[BYTE_W +: WSEL_W];

    logic [WAYS-1:0]  hit_vec, valid_vec;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way, victim_way;
    logic [WORD_W-1:0] rd_data;
    logic             accept, fill_beat, fill_done, write_done;

    assign hit_any    = |hit_vec;
    assign accept     = req_valid && req_ready;
    assign fill_beat  = (state_q == ST_FILL) && mem_ack;
    assign fill_done  = fill_beat && (beat_q == LAST_BEAT);
    assign write_done = (state_q == ST_WRITE) && mem_ack;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    // Storage write and recency touch selection
    logic              d_we;
    logic [IDX_W-1:0]  d_idx;
    logic [WAY_W-1:0]  d_way;
    logic [WSEL_W-1:0] d_word;
    logic [WORD_W-1:0] d_data;
    logic              t_en;
    logic [IDX_W-1:0]  t_idx;
    logic [WAY_W-1:0]  t_way;

    always_comb begin
        d_we   = 1'b0;
        d_idx  = lk_idx;
        d_way  = hit_way;
        d_word = lk_word;
        d_data = req_wdata;
        if (fill_beat) begin
            d_we   = 1'b1;
            d_idx  = cur_idx;
            d_way  = victim_q;
            d_word = beat_q;
            d_data = mem_rdata;
        end else if (accept && req_write && hit_any) begin
            d_we   = 1'b1;
        end
    end

    always_comb begin
        t_en  = 1'b0;
        t_idx = lk_idx;
        t_way = hit_way;
        if (fill_done) begin
            t_en  = 1'b1;
            t_idx = cur_idx;
            t_way = victim_q;
        end else if (accept && hit_any) begin
            t_en  = 1'b1;
        end
    end

    cache_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .inval(inval_all),
        .lk_idx(lk_idx), .lk_tag(lk_tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec),
        .fill_en(fill_done), .fill_idx(cur_idx), .fill_way(victim_q), .fill_tag(cur_tag)
    );

    cache_data_store #(
        .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W),
        .IDX_W(IDX_W), .WAY_W(WAY_W), .WSEL_W(WSEL_W)
    ) u_data (
        .clk(clk),
        .rd_idx(lk_idx), .rd_way(hit_way), .rd_word(lk_word), .rd_data(rd_data),
        .wr_en(d_we), .wr_idx(d_idx), .wr_way(d_way), .wr_word(d_word), .wr_data(d_data)
    );

    cache_lru #(
        .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk(clk), .rst_n(rst_n), .inval(inval_all),
        .touch_en(t_en), .touch_idx(t_idx), .touch_way(t_way),
        .q_idx(lk_idx), .q_valid(valid_vec), .victim_way(victim_way)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write)     state_d = ST_WRITE;
                    else if (!hit_any) state_d = ST_FILL;
                end
            end
            ST_FILL:  if (fill_done)  state_d = ST_IDLE;
            ST_WRITE: if (write_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {cur_addr_q[ADDR_W-1:OFF_W], beat_q, {BYTE_W{1'b0}}};
        mem_wdata = cur_wdata_q;
        unique case (state_q)
            ST_IDLE:  req_ready = !inval_all;
            ST_FILL:  mem_req   = 1'b1;
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_addr_q;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            cur_wdata_q <= '0;
            victim_q    <= '0;
            beat_q      <= '0;
            cap_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            hit_q       <= 1'b0;
            miss_q      <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            hit_q       <= 1'b0;
            miss_q      <= 1'b0;
            if (accept) begin
                cur_addr_q  <= req_addr;
                cur_wdata_q <= req_wdata;
                victim_q    <= victim_way;
                beat_q      <= '0;
                hit_q       <= hit_any;
                miss_q      <= !hit_any;
                if (!req_write && hit_any) begin
                    rsp_valid_q <= 1'b1;
                    rsp_rdata_q <= rd_data;
                end
            end
            if (fill_beat) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == cur_word) cap_q <= mem_rdata;
                if (fill_done) begin
                    rsp_valid_q <= 1'b1;
                    rsp_rdata_q <= (beat_q == cur_word) ? mem_rdata : cap_q;
                end
            end
            if (write_done) rsp_valid_q <= 1'b1;
        end
    end

    assign rsp_valid   = rsp_valid_q;
    assign rsp_rdata   = rsp_rdata_q;
    assign lookup_hit  = hit_q;
    assign lookup_miss = miss_q;
endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inval_all,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              lookup_hit,
    input logic              lookup_miss,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack
);
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    p_rsp_no_traffic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req);

    p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_inval_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> !req_ready);

    p_single_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(lookup_hit && lookup_miss));

    p_outcome_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> $countones({lookup_hit, lookup_miss}) == 1);
endmodule

bind wt_cache cache_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .lookup_hit(lookup_hit), .lookup_miss(lookup_miss),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_wt_cache.sv
module sim_wt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval_all = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        lookup_hit, lookup_miss;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .lookup_hit(lookup_hit), .lookup_miss(lookup_miss),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, failures = 0;
    int exp_hits = 0, exp_misses = 0, dut_hits = 0, dut_misses = 0;
    int lat = 1, cnt = 0;
    bit done = 0;

    logic [31:0] refmem [logic [29:0]];
    logic [20:0] rec [128][$];
    logic [31:0] beat_addr [$];
    logic        beat_we [$];

    function automatic logic [31:0] ref_rd(input logic [29:0] w);
        if (refmem.exists(w)) return refmem[w];
        return ({2'b00, w} * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] ad(input logic [20:0] tg, input logic [6:0] st, input logic [3:0] off);
        return {tg, st, off};
    endfunction

    function automatic bit mdl_hit(input logic [31:0] a);
        foreach (rec[a[10:4]][i]) if (rec[a[10:4]][i] == a[31:11]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void mdl_upd(input bit wr, input logic [31:0] a);
        int pos = -1;
        foreach (rec[a[10:4]][i]) if (rec[a[10:4]][i] == a[31:11]) pos = i;
        if (pos >= 0) begin
            rec[a[10:4]].delete(pos);
            rec[a[10:4]].push_front(a[31:11]);
        end else if (!wr) begin
            if (rec[a[10:4]].size() == 4) void'(rec[a[10:4]].pop_back());
            rec[a[10:4]].push_front(a[31:11]);
        end
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Memory model: acknowledges each beat after lat idle cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_ack = 1'b1;
                cnt = 0;
                beat_addr.push_back(mem_addr);
                beat_we.push_back(mem_we);
                if (mem_we) refmem[mem_addr[31:2]] = mem_wdata;
                else        mem_rdata = ref_rd(mem_addr[31:2]);
            end else begin
                cnt++;
            end
        end
    end

    // Per-clock outcome counter (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (lookup_hit)  dut_hits++;
            if (lookup_miss) dut_misses++;
        end
    end

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          input string why, output bit got_hit);
        bit eh, ok;
        int waits;
        logic [31:0] ev, base;
        eh = mdl_hit(a);
        if (eh) exp_hits++; else exp_misses++;
        beat_addr.delete();
        beat_we.delete();
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_hit = lookup_hit;
        chk(lookup_hit == eh && lookup_miss == !eh, "R11 lookup outcome", {30'd0, lookup_hit, lookup_miss}, {30'd0, eh, !eh});
        waits = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            waits++;
        end
        if (!wr) begin
            ev = ref_rd(a[31:2]);
            chk(rsp_rdata == ev, why, rsp_rdata, ev);
            if (eh) chk(waits == 0, "R2 response one cycle after accept", waits, 0);
        end
        if (wr) begin
            ok = (beat_addr.size() == 1);
            if (ok) ok = beat_we[0] && beat_addr[0] == a && refmem[a[31:2]] == d;
            chk(ok, "R4 single write-through beat", beat_addr.size(), 1);
        end else if (eh) begin
            chk(beat_addr.size() == 0, "R2 hit causes no memory traffic", beat_addr.size(), 0);
        end else begin
            base = {a[31:4], 4'h0};
            ok = (beat_addr.size() == 4);
            for (int k = 0; k < 4; k++)
                if (ok) ok = !beat_we[k] && beat_addr[k] == base + 32'(4 * k);
            chk(ok, "R3 four sequential fill beats", beat_addr.size(), 4);
        end
        mdl_upd(wr, a);
        @(negedge clk);
    endtask

    task automatic rd(input logic [31:0] a, input string why, output bit h);
        access(1'b0, a, 32'h0, why, h);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        chk(mem_req == 1'b0, "R1 memory idle after reset", mem_req, 0);

        // Set 3: first access, same-line words, low address bits
        rd(ad(1, 3, 0), "R3 fill returns word", h);
        chk(!h, "R1 first read misses", h, 0);
        rd(ad(1, 3, 4), "R12 other word of line", h);
        chk(h, "R12 word select within line hits", h, 1);
        rd(ad(1, 3, 5), "R12 byte bits ignored on read", h);
        chk(h, "R12 byte bits ignored hit", h, 1);

        // R7: three more tags fill invalid ways, nothing evicted
        rd(ad(2, 3, 8), "R3 fill word 2", h);
        rd(ad(3, 3, 12), "R3 fill word 3", h);
        rd(ad(4, 3, 0), "R3 fill word 0", h);
        for (int t = 1; t <= 4; t++) begin
            rd(ad(21'(t), 3, 0), "R2 hit data", h);
            chk(h, "R7 all four lines resident", h, 1);
        end

        // R8/R9: read hit on tag 2 makes tag 1 the oldest
        rd(ad(2, 3, 0), "R2 hit data", h);
        rd(ad(5, 3, 0), "R8 fill into full set", h);
        chk(!h, "R8 new tag misses", h, 0);
        rd(ad(1, 3, 0), "R8 evicted line refetched", h);
        chk(!h, "R8 least recent line was evicted", h, 0);
        rd(ad(2, 3, 0), "R9 read-hit line kept", h);
        chk(h, "R9 recently read line survives", h, 1);
        rd(ad(5, 3, 4), "R9 filled line kept", h);
        chk(h, "R9 fill refreshes recency", h, 1);

        // Set 9, zero latency: write hit refreshes and updates
        lat = 0;
        for (int t = 10; t <= 13; t++) rd(ad(21'(t), 9, 0), "R3 fill data", h);
        access(1'b1, ad(10, 9, 8), 32'hCAFE_0001, "R4", h);
        chk(h, "R5 write to resident line hits", h, 1);
        rd(ad(14, 9, 0), "R3 fill data", h);
        rd(ad(10, 9, 8), "R5 cached copy updated by write hit", h);
        chk(h, "R9 write hit refreshes recency", h, 1);
        rd(ad(11, 9, 0), "R8 oldest refetched", h);
        chk(!h, "R8 oldest line evicted after write refresh", h, 0);

        // R6: write miss does not allocate
        access(1'b1, ad(20, 9, 4), 32'h1234_5678, "R4", h);
        chk(!h, "R6 write to absent line misses", h, 0);
        rd(ad(20, 9, 4), "R4 memory holds written word", h);
        chk(!h, "R6 write miss allocated nothing", h, 0);

        // Boundary sets and tags, slow memory
        lat = 3;
        rd(ad(21'h1F_FFFF, 127, 12), "R12 top set top tag fill", h);
        rd(ad(21'h1F_FFFF, 127, 12), "R12 top set hit", h);
        chk(h, "R12 top set hit", h, 1);
        rd(ad(0, 0, 0), "R12 bottom set fill", h);
        chk(!h, "R12 bottom set first miss", h, 0);

        // R10: invalidate-all
        lat = 1;
        inval_all = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready low during invalidate", req_ready, 0);
        inval_all = 1'b0;
        for (int s = 0; s < 128; s++) rec[s].delete();
        @(negedge clk);
        rd(ad(2, 3, 0), "R10 refetch after invalidate", h);
        chk(!h, "R10 resident line invalidated", h, 0);
        rd(ad(21'h1F_FFFF, 127, 12), "R10 refetch top set", h);
        chk(!h, "R10 top set invalidated", h, 0);
        for (int t = 31; t <= 34; t++) rd(ad(21'(t), 3, 0), "R10 fill after reset", h);
        rd(ad(35, 3, 0), "R10 fifth tag", h);
        rd(ad(2, 3, 0), "R10 first filled line evicted", h);
        chk(!h, "R10 recency restarted after invalidate", h, 0);
        rd(ad(34, 3, 0), "R10 newest kept", h);
        chk(h, "R10 newest line resident", h, 1);

        @(negedge clk);
        chk(dut_hits == exp_hits, "R11 hit count", dut_hits, exp_hits);
        chk(dut_misses == exp_misses, "R11 miss count", dut_misses, exp_misses);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule